// File: doc/BRIEF.md
# Motion Event Detector: Activity, Inactivity and Free-Fall

This block watches a stream of three-axis signed acceleration samples and raises three event pulses for an interrupt controller. The activity event fires on any sample in which one of the selected axes is too large. The inactivity event fires once the selected axes have all stayed small for a programmed number of slow time-base ticks. The free-fall event works the same way as inactivity, but it always uses all three axes and has its own threshold, its own length and its own fast time base.

Each sample arrives with a one-cycle valid strobe. The slow and fast time bases arrive as one-cycle tick inputs, typically one per second and one per 5 ms. Thresholds, lengths and axis selections are plain input ports driven by a register block outside this one. Each axis magnitude is the absolute value of the sample. It is compared through its upper threshold-width bits, so an 8-bit threshold covers the full range of a 12-bit sample. All comparisons use the DC sample values.

Top module: `motion_event_detector`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three event outputs are low.
- R2: For each sample strobe, act_evt is high in the following cycle, for one cycle, exactly when a selected axis has a scaled magnitude strictly greater than act_thr. A scaled magnitude equal to the threshold does not count.
- R3: The scaled magnitude of an axis is |sample| shifted right by SAMPLE_W-THR_W bits (bits 11:4 of the 12-bit magnitude by default). A negative sample uses its absolute value, so -2048 scales to 128.
- R4: act_axes bit 0 selects x, bit 1 selects y and bit 2 selects z. An axis whose bit is clear has no effect on act_evt. With act_axes zero, act_evt never fires.
- R5: A sample counts as quiet for inactivity when inact_axes is not zero and every selected axis has a scaled magnitude strictly below inact_thr. After a quiet sample, inact_evt pulses for one cycle on the (inact_len+1)-th tick_slow, counted from the first tick that follows the sample.
- R6: A sample that is not quiet clears the tick count, so the full count restarts from the next quiet sample.
- R7: After inactivity fires, further ticks and quiet samples produce no new pulse until a sample that is not quiet has been seen, followed by a new qualifying interval.
- R8: inact_axes uses the same bit order as act_axes. An axis whose bit is clear does not affect inactivity. With inact_axes zero, inactivity never fires.
- R9: Free-fall counts as quiet only when all three axes have a scaled magnitude strictly below ff_thr, whatever inact_axes holds. ff_evt pulses on the (ff_len+1)-th tick_fast after a quiet sample, and re-arms only after a sample that is not quiet.
- R10: tick_slow does not advance free-fall and tick_fast does not advance inactivity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | SAMPLE_W | Signed x-axis sample |
| smp_y | input | SAMPLE_W | Signed y-axis sample |
| smp_z | input | SAMPLE_W | Signed z-axis sample |
| tick_slow | input | 1 | Inactivity time-base tick |
| tick_fast | input | 1 | Free-fall time-base tick |
| act_thr | input | THR_W | Activity threshold |
| act_axes | input | 3 | Activity axis select (bit0 x, bit1 y, bit2 z) |
| inact_thr | input | THR_W | Inactivity threshold |
| inact_len | input | THR_W | Inactivity length in slow ticks |
| inact_axes | input | 3 | Inactivity axis select (bit0 x, bit1 y, bit2 z) |
| ff_thr | input | THR_W | Free-fall threshold |
| ff_len | input | THR_W | Free-fall length in fast ticks |
| act_evt | output | 1 | Activity event pulse |
| inact_evt | output | 1 | Inactivity event pulse |
| ff_evt | output | 1 | Free-fall event pulse |

## Verification
The assertions assume that samples and ticks are single-cycle strobes. They also assume that the threshold, length and axis-select ports stay still while a timed interval is being counted, because a length that changes in the middle of an interval moves the firing tick. The stimulus changes configuration only between test phases and never drives a sample and a tick in the same cycle. It opens every timer phase with a sample that is large on all axes, so each interval starts from a known, cleared count.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

    localparam int AXES = 3;

    // Per-axis comparison outcome carried from the magnitude stage
    typedef struct packed {
        logic act_over;     // scaled magnitude above activity threshold
        logic inact_below;  // scaled magnitude below inactivity threshold
        logic ff_below;     // scaled magnitude below free-fall threshold
    } axis_cmp_t;

    // State of a quiet-interval timer
    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,    // condition not met, count cleared
        TM_COUNT = 2'd1,    // condition met, counting ticks
        TM_SPENT = 2'd2     // event issued, waiting for a break
    } tmr_state_e;

endpackage

// File: rtl/mdet_axis_cmp.sv
module mdet_axis_cmp
    import mdet_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THR_W    = 8
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [THR_W-1:0]    act_thr,
    input  logic [THR_W-1:0]    inact_thr,
    input  logic [THR_W-1:0]    ff_thr,
    output axis_cmp_t           cmp
);

    localparam int SHIFT = SAMPLE_W - THR_W;

    logic [SAMPLE_W-1:0] mag;
    logic [THR_W-1:0]    scaled;

    // Two's complement absolute value; the most negative code maps to 2^(SAMPLE_W-1)
    always_comb begin
        if (sample[SAMPLE_W-1])
            mag = ~sample + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        else
            mag = sample;
        scaled = mag[SAMPLE_W-1 -: THR_W];
    end

    always_comb begin
        cmp.act_over    = (scaled > act_thr);
        cmp.inact_below = (scaled < inact_thr);
        cmp.ff_below    = (scaled < ff_thr);
    end

    initial begin
        if (SHIFT < 0) $error("SAMPLE_W must be at least THR_W");
    end

endmodule

// File: rtl/mdet_act.sv
module mdet_act
    import mdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_valid,
    input  logic [AXES-1:0] over,
    input  logic [AXES-1:0] axes_sel,
    output logic            act_evt
);

    logic hit;

    always_comb hit = |(over & axes_sel);

    always_ff @(posedge clk) begin
        if (rst) act_evt <= 1'b0;
        else     act_evt <= smp_valid & hit;
    end

    AST_ACT_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        act_evt |-> $past(smp_valid)); // R2

endmodule

// File: rtl/mdet_quiet_timer.sv
module mdet_quiet_timer
    import mdet_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             smp_quiet,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             fire
);

    tmr_state_e       state;
    logic [LEN_W-1:0] count;
    logic             brk;
    logic             enter;
    logic             step;
    logic             done;

    always_comb begin
        brk   = smp_valid & ~smp_quiet;
        enter = smp_valid &  smp_quiet & (state == TM_IDLE);
        step  = tick & (state == TM_COUNT) & ~brk;
        done  = step & (count >= len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TM_IDLE;
            count <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= done;
            if (brk) begin
                state <= TM_IDLE;
                count <= '0;
            end else if (enter) begin
                state <= TM_COUNT;
                count <= '0;
            end else if (done) begin
                state <= TM_SPENT;
            end else if (step) begin
                count <= count + 1'b1;
            end
        end
    end

    AST_FIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(tick)); // R5 R9
    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R7
    AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_quiet) |=> !fire); // R6

endmodule

// File: rtl/motion_event_detector.sv
module motion_event_detector
    import mdet_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THR_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_y,
    input  logic [SAMPLE_W-1:0] smp_z,
    input  logic                tick_slow,
    input  logic                tick_fast,
    input  logic [THR_W-1:0]    act_thr,
    input  logic [2:0]          act_axes,
    input  logic [THR_W-1:0]    inact_thr,
    input  logic [THR_W-1:0]    inact_len,
    input  logic [2:0]          inact_axes,
    input  logic [THR_W-1:0]    ff_thr,
    input  logic [THR_W-1:0]    ff_len,
    output logic                act_evt,
    output logic                inact_evt,
    output logic                ff_evt
);

    logic [SAMPLE_W-1:0] smp_vec [AXES];
    axis_cmp_t           cmp     [AXES];
    logic [AXES-1:0]     over;
    logic [AXES-1:0]     ibelow;
    logic [AXES-1:0]     fbelow;
    logic                inact_quiet;
    logic                ff_quiet;

    always_comb begin
        smp_vec[0] = smp_x;
        smp_vec[1] = smp_y;
        smp_vec[2] = smp_z;
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        mdet_axis_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .THR_W    (THR_W)
        ) u_cmp (
            .sample    (smp_vec[a]),
            .act_thr   (act_thr),
            .inact_thr (inact_thr),
            .ff_thr    (ff_thr),
            .cmp       (cmp[a])
        );
        assign over[a]   = cmp[a].act_over;
        assign ibelow[a] = cmp[a].inact_below;
        assign fbelow[a] = cmp[a].ff_below;
    end

    // Unselected axes pass; an empty selection never counts as quiet
    always_comb begin
        inact_quiet = (|inact_axes) & (&(ibelow | ~inact_axes));
        ff_quiet    = &fbelow;
    end

    mdet_act u_act (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .over      (over),
        .axes_sel  (act_axes),
        .act_evt   (act_evt)
    );

    mdet_quiet_timer #(.LEN_W(THR_W)) u_inact (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_quiet (inact_quiet),
        .tick      (tick_slow),
        .len       (inact_len),
        .fire      (inact_evt)
    );

    mdet_quiet_timer #(.LEN_W(THR_W)) u_ff (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_quiet (ff_quiet),
        .tick      (tick_fast),
        .len       (ff_len),
        .fire      (ff_evt)
    );

    AST_ACT_MASK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && act_axes == 3'b000) |=> !act_evt); // R4
    AST_FF_FAST_BASE: assert property (@(posedge clk) disable iff (rst)
        ff_evt |-> $past(tick_fast)); // R10
    AST_INACT_SLOW_BASE: assert property (@(posedge clk) disable iff (rst)
        inact_evt |-> $past(tick_slow)); // R10

endmodule

// File: tb/tb_motion_event_detector.sv
module tb_motion_event_detector;

    localparam int SW = 12;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic          tick_slow = 1'b0, tick_fast = 1'b0;
    logic [TW-1:0] act_thr = '0, inact_thr = '0, inact_len = '0;
    logic [TW-1:0] ff_thr = '0, ff_len = '0;
    logic [2:0]    act_axes = '0, inact_axes = '0;
    logic          act_evt, inact_evt, ff_evt;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    motion_event_detector #(.SAMPLE_W(SW), .THR_W(TW)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .tick_slow(tick_slow), .tick_fast(tick_fast),
        .act_thr(act_thr), .act_axes(act_axes),
        .inact_thr(inact_thr), .inact_len(inact_len), .inact_axes(inact_axes),
        .ff_thr(ff_thr), .ff_len(ff_len),
        .act_evt(act_evt), .inact_evt(inact_evt), .ff_evt(ff_evt)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one sample; returns at the negedge where the event outputs reflect it
    task automatic sample(input int x, input int y, input int z);
        @(negedge clk);
        smp_x = x[SW-1:0]; smp_y = y[SW-1:0]; smp_z = z[SW-1:0];
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic slow_tick();
        @(negedge clk); tick_slow = 1'b1;
        @(negedge clk); tick_slow = 1'b0;
    endtask

    task automatic fast_tick();
        @(negedge clk); tick_fast = 1'b1;
        @(negedge clk); tick_fast = 1'b0;
    endtask

    function automatic int scaled(input int v);
        int m;
        m = (v < 0) ? -v : v;
        return m >> (SW - TW);
    endfunction

    // Inactivity with all axes: exact firing tick, one-shot, re-arm
    task automatic inact_run(input int len);
        inact_len = len[TW-1:0];
        sample(2000, 2000, 2000);
        sample(0, 0, 0);
        for (int k = 0; k < len; k++) begin
            slow_tick(); chk(inact_evt, 1'b0, "R5 early tick");
        end
        slow_tick(); chk(inact_evt, 1'b1, "R5 firing tick");
        slow_tick(); chk(inact_evt, 1'b0, "R7 no repeat");
        sample(0, 0, 0);
        slow_tick(); chk(inact_evt, 1'b0, "R7 quiet sample does not re-arm");
        sample(2000, 2000, 2000);
        sample(0, 0, 0);
        for (int k = 0; k < len; k++) begin
            slow_tick(); chk(inact_evt, 1'b0, "R7 early tick after re-arm");
        end
        slow_tick(); chk(inact_evt, 1'b1, "R7 fires after re-arm");
    endtask

    initial begin
        int vals [13] = '{-2048, -81, -80, -79, -1, 0, 15, 16, 79, 80, 95, 96, 2047};
        int thrs [3]  = '{0, 5, 127};
        int t;
        logic exp;

        repeat (3) @(negedge clk);
        chk(act_evt, 1'b0, "R1 act in reset");
        chk(inact_evt, 1'b0, "R1 inact in reset");
        chk(ff_evt, 1'b0, "R1 ff in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(act_evt, 1'b0, "R1 act after reset");
        chk(inact_evt, 1'b0, "R1 inact after reset");
        chk(ff_evt, 1'b0, "R1 ff after reset");

        // R2 R3 R4: sweep axis selection, thresholds, values and axis position
        for (int m = 0; m < 8; m++) begin
            act_axes = m[2:0];
            for (int ti = 0; ti < 3; ti++) begin
                act_thr = thrs[ti][TW-1:0];
                for (int a = 0; a < 3; a++) begin
                    for (int vi = 0; vi < 13; vi++) begin
                        exp = m[a] && (scaled(vals[vi]) > thrs[ti]);
                        case (a)
                            0: sample(vals[vi], 0, 0);
                            1: sample(0, vals[vi], 0);
                            default: sample(0, 0, vals[vi]);
                        endcase
                        chk(act_evt, exp, "R2 R3 R4 activity sweep");
                        @(negedge clk);
                        chk(act_evt, 1'b0, "R2 single-cycle pulse");
                    end
                end
            end
        end

        // R5 R7: inactivity over several lengths
        inact_axes = 3'b111; inact_thr = 8'd10;
        ff_thr = 8'd0; ff_len = 8'd0;
        for (int li = 0; li < 4; li++) begin
            t = (li == 3) ? 7 : li;
            inact_run(t);
        end

        // R6: a breaking sample mid-interval restarts the count
        inact_len = 8'd3;
        sample(2000, 2000, 2000);
        sample(0, 0, 0);
        slow_tick(); slow_tick(); slow_tick();
        chk(inact_evt, 1'b0, "R6 before break");
        sample(0, 0, 160);          // scaled 10 equals threshold: breaks
        sample(0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            slow_tick(); chk(inact_evt, 1'b0, "R6 count restarted");
        end
        slow_tick(); chk(inact_evt, 1'b1, "R6 fires after full restart");

        // R8: unselected axes ignored; empty selection never fires
        inact_len = 8'd1; inact_axes = 3'b001;
        sample(2000, 0, 0);
        sample(159, 2000, -2048);   // x scaled 9 < 10
        slow_tick(); chk(inact_evt, 1'b0, "R8 early");
        slow_tick(); chk(inact_evt, 1'b1, "R8 only x selected");
        inact_axes = 3'b000;
        sample(2000, 0, 0);
        sample(0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            slow_tick(); chk(inact_evt, 1'b0, "R8 empty selection");
        end

        // R9 R10: free-fall uses all axes, its own timebase and threshold
        inact_axes = 3'b001; inact_len = 8'd0;
        ff_thr = 8'd20; ff_len = 8'd2;
        sample(2000, 2000, 2000);
        sample(0, 0, 320);          // z scaled 20 not below ff_thr
        for (int k = 0; k < 5; k++) begin
            fast_tick(); chk(ff_evt, 1'b0, "R9 one axis too large");
        end
        slow_tick(); chk(inact_evt, 1'b1, "R9 inactivity unaffected by z");
        chk(ff_evt, 1'b0, "R10 slow tick leaves free-fall");
        sample(-319, 319, 0);       // all scaled 19
        for (int k = 0; k < 4; k++) begin
            slow_tick(); chk(ff_evt, 1'b0, "R10 slow ticks do not advance free-fall");
        end
        fast_tick(); chk(ff_evt, 1'b0, "R9 early");
        fast_tick(); chk(ff_evt, 1'b0, "R9 early");
        chk(inact_evt, 1'b0, "R10 fast tick leaves inactivity");
        fast_tick(); chk(ff_evt, 1'b1, "R9 fires on third fast tick");
        fast_tick(); chk(ff_evt, 1'b0, "R9 no repeat");
        sample(2000, 0, 0);
        sample(0, 0, 0);
        fast_tick(); fast_tick();
        chk(ff_evt, 1'b0, "R9 early after re-arm");
        fast_tick(); chk(ff_evt, 1'b1, "R9 re-armed");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule